// File: doc/BRIEF.md
# Transmit Underrun Status Responder

This block sits between the transmit side of a host interface and a transmit buffer that firmware fills. It reacts when the host asks for transmit data while firmware has not yet marked a frame as ready. On such a request it latches a sticky underrun flag, which is also driven onto a dedicated output line. Both stay high until firmware pulses a clear strobe.

In the same cycle as the request, the block tells the active bus engine how to answer. An I2C engine is asked to NACK the byte. An SPI engine is told to shift out an all-ones fill byte. In UART mode the interface itself starts every transmit transaction, so no underrun is detected there. The per-byte reply needs no interrupt. Routing the status to an interrupt controller, the bus engines and the buffer memory all lie outside the block.

Top module: `tx_underrun_resp`

## Requirements
- R1: While reset is asserted and after it is released, the underrun status and the underrun line are 0 until an underrun request occurs.
- R2: A data request with the data-ready flag low, in I2C mode (bus_mode 2'b00) or SPI mode (bus_mode 2'b01), sets the underrun status on the next clock edge.
- R3: Once set, the underrun status stays 1 until a cycle with the clear strobe high. A clear with no new underrun request drops it to 0 on the next edge.
- R4: When the clear strobe and a new underrun request occur in the same cycle, the status is 1 after the edge.
- R5: In I2C mode, the NACK request is high in the request cycle only when the request sees the data-ready flag low. The fill-byte select stays low.
- R6: In SPI mode, the fill-byte select (0xFF fill) is high in the request cycle only when the request sees the data-ready flag low. The NACK request stays low.
- R7: In UART mode (bus_mode 2'b10) and for the unused code 2'b11, a request never sets the status and never raises the NACK request or the fill-byte select.
- R8: A request with the data-ready flag high leaves the status unchanged and raises neither the NACK request nor the fill-byte select.
- R9: With no data request in a cycle, the NACK request and the fill-byte select are both low, and the status changes only through the clear strobe.
- R10: The underrun line always carries the same value as the underrun status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_ready | input | 1 | Firmware marks a transmit frame as available |
| data_req | input | 1 | Single-cycle pulse: the host asks for transmit data |
| bus_mode | input | 2 | 00 I2C, 01 SPI, 10 UART, 11 unused |
| fw_clear | input | 1 | Firmware pulse that clears the underrun status |
| urun_status | output | 1 | Sticky underrun status bit |
| urun_line | output | 1 | Underrun output line, mirrors the status |
| i2c_nack | output | 1 | Request-cycle qualifier: answer the byte with a NACK |
| spi_fill_sel | output | 1 | Request-cycle qualifier: shift out the 0xFF fill byte |

## Verification
The hardest case to reach from the ports is the collision of a clear strobe with a fresh underrun request in the same cycle. The status must already be set for a wrong priority to show, so the collision has to follow an earlier underrun. Directed sequences first set the flag and then apply the clear together with a starved request in each mode. A long random run draws requests, clears and modes with a bias toward a low data-ready flag, so that collisions and set-while-set cases also recur during the run.

// File: rtl/txu_pkg.sv
package txu_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        BUS_I2C  = 2'b00,
        BUS_SPI  = 2'b01,
        BUS_UART = 2'b10,
        BUS_NONE = 2'b11
    } bus_mode_e;

    typedef struct packed {
        logic flag;
    } urun_state_t;
endpackage

// File: rtl/txu_detect.sv
module txu_detect
    import txu_pkg::*;
(
    input  logic              data_req,
    input  logic              data_ready,
    input  logic [MODE_W-1:0] bus_mode,
    output logic              urun_evt,
    output logic              nack_req,
    output logic              fill_sel
);
    logic starved;

    always_comb begin
        starved  = data_req & ~data_ready;
        urun_evt = 1'b0;
        nack_req = 1'b0;
        fill_sel = 1'b0;
        case (bus_mode_e'(bus_mode))
            BUS_I2C: begin
                urun_evt = starved;
                nack_req = starved;
            end
            BUS_SPI: begin
                urun_evt = starved;
                fill_sel = starved;
            end
            default: begin
                urun_evt = 1'b0;
            end
        endcase
    end

    // R5 R6
    always_comb begin
        qual_exclusive_chk: assert ($onehot0({nack_req, fill_sel}));
    end

    // R7
    always_comb begin
        if (bus_mode[1]) begin
            uart_quiet_chk: assert (!urun_evt && !nack_req && !fill_sel);
        end
    end

    // R8 R9
    always_comb begin
        if (!data_req || data_ready) begin
            no_req_quiet_chk: assert (!urun_evt && !nack_req && !fill_sel);
        end
    end
endmodule

// File: rtl/txu_status_reg.sv
module txu_status_reg
    import txu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    urun_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_evt) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R2 R4
    set_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);

    // R3
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !flag);

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_evt && !clr_req) |=> $stable(flag));
endmodule

// File: rtl/tx_underrun_resp.sv
module tx_underrun_resp
    import txu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_ready,
    input  logic              data_req,
    input  logic [MODE_W-1:0] bus_mode,
    input  logic              fw_clear,
    output logic              urun_status,
    output logic              urun_line,
    output logic              i2c_nack,
    output logic              spi_fill_sel
);
    logic urun_evt;
    logic flag;

    txu_detect u_detect (
        .data_req   (data_req),
        .data_ready (data_ready),
        .bus_mode   (bus_mode),
        .urun_evt   (urun_evt),
        .nack_req   (i2c_nack),
        .fill_sel   (spi_fill_sel)
    );

    txu_status_reg u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (urun_evt),
        .clr_req (fw_clear),
        .flag    (flag)
    );

    assign urun_status = flag;
    assign urun_line   = flag;

    // R2
    starved_i2c_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && !data_ready && bus_mode == 2'b00) |=> urun_status);

    // R8
    ready_req_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && data_ready && !fw_clear) |=> $stable(urun_status));
endmodule

// File: tb/tx_underrun_resp_bench.sv
module tx_underrun_resp_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_ready = 1'b0;
    logic       data_req = 1'b0;
    logic [1:0] bus_mode = 2'b00;
    logic       fw_clear = 1'b0;
    logic       urun_status, urun_line, i2c_nack, spi_fill_sel;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  exp_st = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    tx_underrun_resp u_tx_underrun_resp (
        .clk(clk), .rst_n(rst_n), .data_ready(data_ready), .data_req(data_req),
        .bus_mode(bus_mode), .fw_clear(fw_clear), .urun_status(urun_status),
        .urun_line(urun_line), .i2c_nack(i2c_nack), .spi_fill_sel(spi_fill_sel)
    );

    function automatic bit f_evt(bit req, bit rdy, logic [1:0] m);
        return req && !rdy && (m == 2'b00 || m == 2'b01);
    endfunction
    function automatic bit f_nack(bit req, bit rdy, logic [1:0] m);
        return req && !rdy && m == 2'b00;
    endfunction
    function automatic bit f_fill(bit req, bit rdy, logic [1:0] m);
        return req && !rdy && m == 2'b01;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit req, bit rdy, logic [1:0] m, bit clr, string tag);
        @(negedge clk);
        chk({tag, " status (R2 R3 R4)"}, urun_status, exp_st);
        chk("R10 line", urun_line, exp_st);
        data_req = req; data_ready = rdy; bus_mode = m; fw_clear = clr;
        #1;
        chk({tag, " nack (R5 R7 R8 R9)"}, i2c_nack, f_nack(req, rdy, m));
        chk({tag, " fill (R6 R7 R8 R9)"}, spi_fill_sel, f_fill(req, rdy, m));
        if (f_evt(req, rdy, m)) exp_st = 1'b1;
        else if (clr) exp_st = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 status in reset", urun_status, 1'b0);
        chk("R1 line in reset", urun_line, 1'b0);
        rst_n = 1'b1;
        // R1: idle after reset
        step(0, 0, 2'b00, 0, "R1");
        step(0, 1, 2'b01, 0, "R1");
        // R7: UART and unused code never set
        step(1, 0, 2'b10, 0, "R7");
        step(1, 0, 2'b11, 0, "R7");
        // R8: ready request ignored
        step(1, 1, 2'b00, 0, "R8");
        step(1, 1, 2'b01, 0, "R8");
        // R2 R5: I2C starved request
        step(1, 0, 2'b00, 0, "R5");
        // R3: sticky hold through idle, UART, ready requests
        step(0, 0, 2'b00, 0, "R3");
        step(1, 0, 2'b10, 0, "R3");
        step(1, 1, 2'b01, 0, "R3");
        // R3: clear
        step(0, 0, 2'b00, 1, "R3");
        step(0, 0, 2'b00, 0, "R3");
        // R6: SPI starved request
        step(1, 0, 2'b01, 0, "R6");
        // R4: clear collides with new set, both modes
        step(1, 0, 2'b01, 1, "R4");
        step(1, 0, 2'b00, 1, "R4");
        step(0, 0, 2'b00, 0, "R4");
        step(0, 0, 2'b00, 1, "R3");
        // R4: collision from cleared state
        step(1, 0, 2'b00, 1, "R4");
        // R9: clear with UART request drops status
        step(1, 0, 2'b10, 1, "R9");
        step(0, 0, 2'b00, 0, "R9");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit rq = ($urandom % 3) != 0;
            bit rd = ($urandom % 3) == 0;
            bit cl = ($urandom % 5) == 0;
            logic [1:0] md = 2'($urandom % 4);
            step(rq, rd, md, cl, "rand");
        end
        step(0, 0, 2'b00, 0, "final");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule